// File: doc/BRIEF.md
# PWM Period and High-Time Meter

This block measures an external pulse-width-modulated signal in units of an internal time base. A single input pin feeds two capture units: one samples a free-running counter on rising edges, the other on falling edges. After a start pulse the block waits for two rising-edge captures. For each one it takes a snapshot of both capture registers. From the three counter values it obtains (first rise, last fall, second rise) it computes a raw period count and a raw high-time count. It then raises a done flag, or raises a timeout flag if the second rise never comes.

The time base advances once every `psc_val + 1` clocks and counts modulo `wrap_val`, so every difference is taken modulo the counter length. An optional input divider makes each capture unit fire only on every 2^n-th qualifying edge, which stretches the measured window over 2^n input periods for finer resolution. The high-time result is corrected for two artefacts. The first is a falling-edge capture that overwrites its register before the snapshot reads it. The second is a measurement that begins during the high phase while the divider is active. Scaling to physical time is left to the consumer.

Top module: `pwm_meter`

## Requirements
- R1: After reset, `period_o`, `duty_o`, `done_o` and `timeout_o` are 0. A `start` pulse acts as an update event. It loads `psc_val`, `wrap_val`, `icpsc_code`, `tmo_val` and `single_mode` into active copies, zeroes the time base, and clears `done_o`, `timeout_o`, `period_o` and `duty_o`.
- R2: The time-base counter advances by one every `psc+1` clock cycles. It counts 0 .. `wrap-1` and then returns to 0. Results are in counter units, so an input period of 40 clocks with psc=3 measures as 10.
- R3: `pwm_in` passes through a two-flop synchronizer. Capture unit 0 latches the counter on rising edges and capture unit 1 latches it on falling edges.
- R4: Two cycles after each rising capture, both capture registers are sampled. The first sample gives t0. The second sample gives t2 (from the rising unit) and t1 (from the falling unit). The period is t2−t0 and the raw duty is t1−t0.
- R5: When a later value b is smaller than t0, the difference is `wrap − t0 + b`; otherwise it is `b − t0`.
- R6: If the raw duty exceeds the period, the period is subtracted from the duty. This applies, for example, when a 1-clock high pulse lets the falling capture overwrite its register before the second sample.
- R7: With input divider code n (0..3) each capture unit latches only on every 2^n-th qualifying edge, counted from the start pulse. The reported period then spans 2^n input periods.
- R8: With n≠0 and duty ≥ period>>n, the duty becomes (period>>n) − (period − duty). This yields the true high time when the measurement starts in the high phase.
- R9: If `tmo_val` counter ticks elapse after start before the second rising capture, `timeout_o` rises and `done_o` stays 0. `done_o` and `timeout_o` are never both 1.
- R10: With `single_mode` captured as 1, the reported duty is 0.
- R11: `abort` returns the block to idle and clears `done_o` and `timeout_o`. No result is reported afterwards until the next start. `abort` wins over a simultaneous `start`.
- R12: `done_o`, `period_o` and `duty_o` stay unchanged until the next `start` or `abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Asynchronous signal being measured |
| psc_val | input | PSC_W | Time-base divider value (advance every psc+1 clocks) |
| wrap_val | input | CNT_W | Counter modulus |
| icpsc_code | input | 2 | Input divider code n, capture every 2^n edges |
| tmo_val | input | TMO_W | Timeout limit in counter ticks |
| single_mode | input | 1 | 1: report duty as zero |
| start | input | 1 | Update event and measurement start (1-cycle pulse) |
| abort | input | 1 | Stop measurement and clear flags |
| period_o | output | CNT_W | Raw period count |
| duty_o | output | CNT_W | Raw high-time count |
| done_o | output | 1 | Result valid |
| timeout_o | output | 1 | Second rising capture missing |

## Verification
The meter is driven with square waves of several period/high-time pairs, with prescaler 0 and 3, so the results separate plain edge differencing from time-base scaling. A counter modulus just above the input period forces every period and most duty differences to cross the wrap point, which exposes the modulo formula. A 1-clock high pulse triggers the overwritten-falling-capture case. Input divider codes 1, 2 and 3, started in the low phase and in the high phase, tell the plain path apart from the high-phase correction. A constant-low input, a single-channel run and an abort mid-measurement cover the timeout flag, the forced zero duty and the return to idle.

// File: rtl/pwm_meter_pkg.sv
package pwm_meter_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_MEAS,
    ST_DRAIN,
    ST_CALC
  } meas_state_t;
endpackage

// File: rtl/pwm_meter_front.sv
module pwm_meter_front #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], sig_i};
      last_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise_o = sync_q[SYNC_N-1] & ~last_q;
  assign fall_o = ~sync_q[SYNC_N-1] & last_q;
endmodule

// File: rtl/pwm_meter_timebase.sv
module pwm_meter_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] wrap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [PSC_W-1:0] pre_q;
  logic [CNT_W-1:0] top_val;

  assign top_val = wrap_i - 1'b1;
  assign tick_o  = run_i && !clr_i && (pre_q == psc_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_o <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      cnt_o <= '0;
    end else if (tick_o) begin
      pre_q <= '0;
      cnt_o <= (cnt_o >= top_val) ? '0 : cnt_o + 1'b1;
    end else if (run_i) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R2: counter stays below the modulus
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    (wrap_i != '0) |-> (cnt_o < wrap_i));

  // R2: with a nonzero divider two ticks are never adjacent
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_o && psc_i != '0) |=> !tick_o);
endmodule

// File: rtl/pwm_meter_capunit.sv
module pwm_meter_capunit #(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              edge_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  cap_o,
  output logic              hit_o
);
  localparam int DIV_W = (1 << CODE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask  = ~({DIV_W{1'b1}} << code_i);
  assign hit_o = en_i && !clr_i && edge_i && (div_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cap_o <= '0;
    end else if (clr_i) begin
      div_q <= '0;
    end else if (en_i && edge_i) begin
      div_q <= (div_q + 1'b1) & mask;
      if (hit_o) cap_o <= cnt_i;
    end
  end

  // R3: the capture register only moves after a qualifying edge
  p_cap_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_o) |-> $past(en_i && edge_i));
endmodule

// File: rtl/pwm_meter_calc.sv
module pwm_meter_calc #(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 2
) (
  input  logic [CNT_W-1:0]  t0_i,
  input  logic [CNT_W-1:0]  t1_i,
  input  logic [CNT_W-1:0]  t2_i,
  input  logic [CNT_W-1:0]  wrap_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              single_i,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  duty_o
);
  function automatic logic [CNT_W-1:0] wdiff(input logic [CNT_W-1:0] a,
                                             input logic [CNT_W-1:0] b,
                                             input logic [CNT_W-1:0] m);
    if (b >= a) return b - a;
    else        return m - a + b;
  endfunction

  logic [CNT_W-1:0] raw_duty, race_duty, per_div, phase_duty;

  always_comb begin
    period_o   = wdiff(t0_i, t2_i, wrap_i);
    raw_duty   = wdiff(t0_i, t1_i, wrap_i);
    race_duty  = (raw_duty > period_o) ? raw_duty - period_o : raw_duty;
    per_div    = period_o >> code_i;
    phase_duty = race_duty;
    if (code_i != '0 && race_duty >= per_div)
      phase_duty = per_div - (period_o - race_duty);
    duty_o     = single_i ? '0 : phase_duty;
  end
endmodule

// File: rtl/pwm_meter.sv
module pwm_meter #(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int TMO_W  = 24,
  parameter int SYNC_N = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              pwm_in,
  input  logic [PSC_W-1:0]                  psc_val,
  input  logic [CNT_W-1:0]                  wrap_val,
  input  logic [pwm_meter_pkg::CODE_W-1:0]  icpsc_code,
  input  logic [TMO_W-1:0]                  tmo_val,
  input  logic                              single_mode,
  input  logic                              start,
  input  logic                              abort,
  output logic [CNT_W-1:0]                  period_o,
  output logic [CNT_W-1:0]                  duty_o,
  output logic                              done_o,
  output logic                              timeout_o
);
  import pwm_meter_pkg::*;

  localparam int N_CAP = 2;

  meas_state_t       state_q;
  logic [PSC_W-1:0]  psc_a;
  logic [CNT_W-1:0]  wrap_a;
  logic [CODE_W-1:0] code_a;
  logic [TMO_W-1:0]  tmo_a;
  logic              single_a;
  logic [1:0]        lag_q;
  logic              snap_n;
  logic [TMO_W-1:0]  tcnt_q;
  logic [CNT_W-1:0]  t0_q, t1_q, t2_q;

  logic              rise_e, fall_e, tick, run, clr, tmo_hit;
  logic [CNT_W-1:0]  cnt;
  logic [N_CAP-1:0]  edge_v, en_v, hit_v;
  logic [CNT_W-1:0]  cap_v [N_CAP];
  logic [CNT_W-1:0]  calc_per, calc_duty;

  assign clr = start && !abort;
  assign run = (state_q != ST_IDLE);

  pwm_meter_front #(.SYNC_N(SYNC_N)) u_front (
    .clk(clk), .rst(rst), .sig_i(pwm_in), .rise_o(rise_e), .fall_o(fall_e)
  );

  pwm_meter_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst(rst), .clr_i(clr), .run_i(run), .psc_i(psc_a),
    .wrap_i(wrap_a), .cnt_o(cnt), .tick_o(tick)
  );

  assign edge_v = {fall_e, rise_e};
  assign en_v[0] = (state_q == ST_ARM) || (state_q == ST_MEAS);
  assign en_v[1] = en_v[0] || (state_q == ST_DRAIN);

  for (genvar gi = 0; gi < N_CAP; gi++) begin : g_cap
    pwm_meter_capunit #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_cap (
      .clk(clk), .rst(rst), .clr_i(clr), .en_i(en_v[gi]),
      .edge_i(edge_v[gi]), .code_i(code_a), .cnt_i(cnt),
      .cap_o(cap_v[gi]), .hit_o(hit_v[gi])
    );
  end

  pwm_meter_calc #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_calc (
    .t0_i(t0_q), .t1_i(t1_q), .t2_i(t2_q), .wrap_i(wrap_a),
    .code_i(code_a), .single_i(single_a),
    .period_o(calc_per), .duty_o(calc_duty)
  );

  assign tmo_hit = tick && ((tcnt_q + 1'b1) >= tmo_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      psc_a     <= '0;
      wrap_a    <= '0;
      code_a    <= '0;
      tmo_a     <= '0;
      single_a  <= 1'b0;
      lag_q     <= '0;
      snap_n    <= 1'b0;
      tcnt_q    <= '0;
      t0_q      <= '0;
      t1_q      <= '0;
      t2_q      <= '0;
      period_o  <= '0;
      duty_o    <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else if (abort) begin
      state_q   <= ST_IDLE;
      lag_q     <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else if (start) begin
      state_q   <= ST_ARM;
      psc_a     <= psc_val;
      wrap_a    <= wrap_val;
      code_a    <= icpsc_code;
      tmo_a     <= tmo_val;
      single_a  <= single_mode;
      lag_q     <= '0;
      snap_n    <= 1'b0;
      tcnt_q    <= '0;
      period_o  <= '0;
      duty_o    <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      lag_q <= {lag_q[0], hit_v[0]};
      case (state_q)
        ST_ARM, ST_MEAS: begin
          if (hit_v[0]) begin
            state_q <= (state_q == ST_ARM) ? ST_MEAS : ST_DRAIN;
          end else if (tmo_hit) begin
            timeout_o <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_CALC: begin
          period_o <= calc_per;
          duty_o   <= calc_duty;
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: ;
      endcase
      if (lag_q[1]) begin
        if (!snap_n) begin
          t0_q   <= cap_v[0];
          snap_n <= 1'b1;
        end else begin
          t2_q    <= cap_v[0];
          t1_q    <= cap_v[1];
          state_q <= ST_CALC;
        end
      end
    end
  end

  // R9: the two completion flags exclude each other
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(done_o && timeout_o));

  // R12: a reported result holds until start or abort
  p_done_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start && !abort) |=> (done_o && $stable(period_o) && $stable(duty_o)));

  // R11: abort clears both flags on the next cycle
  p_abort_clear_r11: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!done_o && !timeout_o));

  // R10: single-channel configuration never reports a duty
  p_single_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && single_a) |-> (duty_o == '0));
endmodule

// File: tb/sim_pwm_meter.sv
`timescale 1ns/1ps
module sim_pwm_meter;
  localparam int CNT_W = 16;
  localparam int PSC_W = 16;
  localparam int TMO_W = 24;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pwm_in = 1'b0;
  logic [PSC_W-1:0] psc_val = '0;
  logic [CNT_W-1:0] wrap_val = '0;
  logic [1:0]       icpsc_code = '0;
  logic [TMO_W-1:0] tmo_val = '0;
  logic             single_mode = 1'b0;
  logic             start = 1'b0;
  logic             abort = 1'b0;
  logic [CNT_W-1:0] period_o, duty_o;
  logic             done_o, timeout_o;

  always #2 clk = ~clk;

  pwm_meter #(.CNT_W(CNT_W), .PSC_W(PSC_W), .TMO_W(TMO_W)) u0 (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .psc_val(psc_val),
    .wrap_val(wrap_val), .icpsc_code(icpsc_code), .tmo_val(tmo_val),
    .single_mode(single_mode), .start(start), .abort(abort),
    .period_o(period_o), .duty_o(duty_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  typedef struct {
    int    per;
    int    duty;
    bit    to;
    string req;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   gp = 0;
  int   gh = 0;
  int   ph = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // square-wave generator, updates just after the rising clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (gp == 0) begin
        ph = 0;
        pwm_in = 1'b0;
      end else begin
        ph = (ph + 1 >= gp) ? 0 : ph + 1;
        pwm_in = (ph < gh);
      end
    end
  end

  // monitor: on each new completion flag pop and compare
  initial begin
    bit   prev;
    exp_t e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if ((done_o || timeout_o) && !prev) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R12", "unexpected completion", 1, 0);
        end else begin
          e = sbq.pop_front();
          chk(timeout_o == e.to, e.req, "timeout flag", timeout_o, e.to);
          chk(done_o == !e.to, e.req, "done flag", done_o, !e.to);
          if (!e.to) begin
            chk(period_o == e.per, e.req, "period", period_o, e.per);
            chk(duty_o == e.duty, e.req, "duty", duty_o, e.duty);
          end
        end
      end
      prev = done_o || timeout_o;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int k;
    k = 0;
    while (!(done_o || timeout_o) && k < 20000) begin
      @(negedge clk);
      k++;
    end
    if (k >= 20000) chk(1'b0, req, "no completion", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_meas(input int psc, input int wrap, input int code,
                          input bit sing, input int p, input int h, input bit hi,
                          input int eper, input int eduty, input string req);
    int target;
    @(negedge clk);
    gp = p;
    gh = h;
    psc_val = PSC_W'(psc);
    wrap_val = CNT_W'(wrap);
    icpsc_code = 2'(code);
    tmo_val = TMO_W'(1000);
    single_mode = sing;
    repeat (2 * p + 4) @(negedge clk);
    target = hi ? h / 2 : h + (p - h) / 2;
    while (ph != target) @(negedge clk);
    sbq.push_back('{eper, eduty, 1'b0, req});
    pulse_start();
    wait_flag(req);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(period_o == 0 && duty_o == 0 && !done_o && !timeout_o, "R1",
        "reset outputs", {period_o, duty_o, done_o, timeout_o}, 0);

    // R3, R4: plain measurement
    run_meas(0, 1000, 0, 0, 20, 7, 0, 20, 7, "R3,R4");
    // R12: result held
    repeat (40) @(negedge clk);
    chk(done_o == 1'b1, "R12", "done held", done_o, 1);
    chk(period_o == 20 && duty_o == 7, "R12", "result held", period_o, 20);

    run_meas(0, 1000, 0, 0, 33, 20, 1, 33, 20, "R4");
    // R2: time-base divider
    run_meas(3, 1000, 0, 0, 40, 12, 0, 10, 3, "R2");
    // R5: modulus just above period
    run_meas(0, 13, 0, 0, 12, 5, 0, 12, 5, "R5");
    run_meas(0, 13, 0, 0, 12, 9, 1, 12, 9, "R5");
    // R6: 1-clock high pulse overwrites falling capture
    run_meas(0, 1000, 0, 0, 20, 1, 0, 20, 1, "R6");
    // R7: input divider, start in low phase
    run_meas(0, 1000, 1, 0, 20, 6, 0, 40, 6, "R7");
    run_meas(0, 1000, 3, 0, 10, 4, 0, 80, 4, "R7");
    // R8: input divider, start in high phase
    run_meas(0, 1000, 1, 0, 20, 6, 1, 40, 6, "R8");
    run_meas(0, 1000, 2, 0, 16, 7, 1, 64, 7, "R8");
    // R10: single-channel configuration
    run_meas(0, 1000, 0, 1, 20, 7, 0, 20, 0, "R10");

    // R9: no edges -> timeout after tmo ticks
    @(negedge clk);
    gp = 0;
    psc_val = '0;
    wrap_val = CNT_W'(1000);
    icpsc_code = '0;
    single_mode = 1'b0;
    tmo_val = TMO_W'(50);
    repeat (4) @(negedge clk);
    sbq.push_back('{0, 0, 1'b1, "R9"});
    pulse_start();
    // R1: start clears the previous done flag
    chk(!done_o && !timeout_o, "R1", "flags after start", {done_o, timeout_o}, 0);
    repeat (30) @(negedge clk);
    chk(!timeout_o, "R9", "timeout too early", timeout_o, 0);
    wait_flag("R9");

    // R11: abort mid-measurement
    gp = 20;
    gh = 7;
    tmo_val = TMO_W'(1000);
    repeat (45) @(negedge clk);
    pulse_start();
    // R1: start clears the previous timeout flag
    chk(!timeout_o, "R1", "timeout after start", timeout_o, 0);
    repeat (5) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    repeat (200) @(negedge clk);
    chk(!done_o && !timeout_o, "R11", "flags after abort", {done_o, timeout_o}, 0);

    chk(sbq.size() == 0, "R12", "pending expected results", sbq.size(), 0);
    summary();
    $finish;
  end
endmodule